// File: doc/BRIEF.md
# Bus Quiet-Time and Transmit-Permit Timer

This block sits beside the receiver of a node on a shared half-duplex serial bus. It counts the bit-times during which the receive line has stayed high. From that count it produces three decisions for the frame logic. The first is whether the bus is idle. The second is whether this node may start a pending frame now. The third, in break-sync mode, is whether a break character must be sent first to wake the bus.

Each node gets its own permit delay, and that delay sets its priority. A node with a shorter delay reaches its permit point earlier than the others. Its start bit then restarts every other node's quiet count. In break-sync mode, a node that had nothing pending at its permit point gives up that slot. If a frame arrives later, the node waits until the quiet time passes a maximum length. It then asks for a break character, which pulls the bus out of idle. After the break it competes again at its normal permit point.

The block also flags received break characters. It accepts a software request to send a break, but only while the bus is idle.

Top module: `bus_quiet_timer`

## Requirements
- R1: While reset is active and in the first cycle after it, bus_idle, tx_permit, break_req and break_seen are all 0.
- R2: The quiet counter increases by one on each cycle with bit_tick high and rx high. It becomes 0 in the cycle after rx is sampled low. It holds at its all-ones value instead of wrapping.
- R3: bus_idle is 1 exactly when the quiet count is greater than or equal to idle_len.
- R4: With bs_mode low, tx_permit is 1 exactly when rx is high and the quiet count is greater than or equal to permit_len. It falls in the same cycle that rx goes low.
- R5: With bs_mode high, any cycle in which the quiet count is at or past permit_len while tx_pending is low withdraws permission. Permission stays withdrawn until rx is next sampled low. A frame pending through the permit point is permitted there.
- R6: With bs_mode high and permission withdrawn, break_req rises in the cycle after a cycle that has both tx_pending high and a quiet count greater than max_idle_len. break_req stays high until rx is sampled low.
- R7: break_seen pulses high for one cycle. The pulse comes in the cycle after rx is sampled high following a low period that spanned at least BREAK_BITS bit ticks.
- R8: A sw_break pulse raises break_req in the next cycle if bus_idle is 1. A sw_break pulse while bus_idle is 0 is ignored, and break_req stays 0.
- R9: With bs_mode low, tx_pending has no effect on tx_permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rx | input | 1 | Synchronized receive line, high when quiet |
| bs_mode | input | 1 | Break-sync mode select |
| tx_pending | input | 1 | A frame is waiting to be sent |
| sw_break | input | 1 | Software request for a break character |
| idle_len | input | IDLE_W | Quiet bit-times needed to declare idle |
| permit_len | input | CNT_W | Quiet bit-times needed before transmitting |
| max_idle_len | input | CNT_W | Quiet limit after which break-sync mode wakes the bus |
| bus_idle | output | 1 | Bus is idle |
| tx_permit | output | 1 | Pending frame may start now |
| break_req | output | 1 | Send a break character |
| break_seen | output | 1 | One-cycle flag for a received break |

## Verification
A quiet count that is off by one shows up first as bus_idle or tx_permit changing one cycle early or late relative to the tick count. A count that wraps would drop bus_idle after about a thousand quiet ticks. A stale withdrawn-permission flag in break-sync mode shows as tx_permit missing, or present, at the permit point of the next quiet period. A low-period counter that is too short or too long shows as a wrong break_seen pulse on the first rising rx edge after a low burst. Because every output depends on these few registers within one or two cycles, a cycle-accurate reference model compared at every cycle catches most faults within one quiet period.

// File: rtl/bus_quiet_timer.sv
`timescale 1ns/1ps
module bus_quiet_timer #(
  parameter int CNT_W      = 10,
  parameter int IDLE_W     = 8,
  parameter int BREAK_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rx,
  input  logic              bs_mode,
  input  logic              tx_pending,
  input  logic              sw_break,
  input  logic [IDLE_W-1:0] idle_len,
  input  logic [CNT_W-1:0]  permit_len,
  input  logic [CNT_W-1:0]  max_idle_len,
  output logic              bus_idle,
  output logic              tx_permit,
  output logic              break_req,
  output logic              break_seen
);
  localparam int LOW_W = $clog2(BREAK_BITS + 1);
  localparam logic [CNT_W-1:0] QMAX = {CNT_W{1'b1}};
  localparam logic [LOW_W-1:0] LMAX = LOW_W'(BREAK_BITS);

  logic [CNT_W-1:0] quiet;
  logic [LOW_W-1:0] low_cnt;
  logic             rx_q;
  logic             missed;

  wire past_permit = quiet >= permit_len;
  wire auto_brk    = bs_mode && missed && (quiet > max_idle_len) && tx_pending;

  assign bus_idle  = quiet >= CNT_W'(idle_len);
  assign tx_permit = rx && past_permit && !(bs_mode && missed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet      <= '0;
      low_cnt    <= '0;
      rx_q       <= 1'b1;
      missed     <= 1'b0;
      break_req  <= 1'b0;
      break_seen <= 1'b0;
    end else begin
      rx_q       <= rx;
      break_seen <= !rx_q && rx && (low_cnt == LMAX);

      if (!rx)                             quiet <= '0;
      else if (bit_tick && quiet != QMAX)  quiet <= quiet + 1'b1;

      if (rx)                              low_cnt <= '0;
      else if (bit_tick && low_cnt != LMAX) low_cnt <= low_cnt + 1'b1;

      if (!rx || !bs_mode)                 missed <= 1'b0;
      else if (past_permit && !tx_pending) missed <= 1'b1;

      if (!rx)                                       break_req <= 1'b0;
      else if (auto_brk || (sw_break && bus_idle))   break_req <= 1'b1;
    end
  end
endmodule

module bus_quiet_timer_chk #(
  parameter int CNT_W  = 10,
  parameter int IDLE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx,
  input logic              bs_mode,
  input logic              tx_pending,
  input logic              sw_break,
  input logic [IDLE_W-1:0] idle_len,
  input logic [CNT_W-1:0]  permit_len,
  input logic              bus_idle,
  input logic              tx_permit,
  input logic              break_req,
  input logic              break_seen
);
  a_r4_permit_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> rx);
  a_r2_low_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx) ##1 (permit_len != '0) |-> !tx_permit);
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && rx) |=> (bus_idle || idle_len != $past(idle_len)));
  a_r7_seen_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    break_seen |-> ($past(rx) && !$past(rx, 2)));
  a_r8_break_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_req) |-> $past(rx));
  a_r6_auto_break_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(break_req) && !$past(sw_break)) |-> $past(bs_mode && tx_pending));
  a_r7_seen_single: assert property (@(posedge clk) disable iff (!rst_n)
    break_seen |=> !break_seen);
endmodule

bind bus_quiet_timer bus_quiet_timer_chk #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx(rx), .bs_mode(bs_mode), .tx_pending(tx_pending),
  .sw_break(sw_break), .idle_len(idle_len), .permit_len(permit_len),
  .bus_idle(bus_idle), .tx_permit(tx_permit), .break_req(break_req),
  .break_seen(break_seen));

// File: tb/bus_quiet_timer_tb.sv
`timescale 1ns/1ps
module bus_quiet_timer_tb_top;
  localparam int CNT_W = 10, IDLE_W = 8, BRK = 10;
  localparam int QMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, bit_tick = 0, rx = 1, bs_mode = 0, tx_pending = 0, sw_break = 0;
  logic [IDLE_W-1:0] idle_len = 10;
  logic [CNT_W-1:0]  permit_len = 20, max_idle_len = 200;
  logic bus_idle, tx_permit, break_req, break_seen;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_quiet, m_low, m_rxq, m_missed, m_brk, m_seen;

  always #2.5 clk = ~clk;

  bus_quiet_timer #(.CNT_W(CNT_W), .IDLE_W(IDLE_W), .BREAK_BITS(BRK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx(rx), .bs_mode(bs_mode),
    .tx_pending(tx_pending), .sw_break(sw_break), .idle_len(idle_len),
    .permit_len(permit_len), .max_idle_len(max_idle_len), .bus_idle(bus_idle),
    .tx_permit(tx_permit), .break_req(break_req), .break_seen(break_seen));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_idle();
    return int'(m_quiet >= int'(idle_len));
  endfunction
  function automatic int exp_permit();
    return int'(rx && m_quiet >= int'(permit_len) && !(bs_mode && m_missed));
  endfunction

  task automatic model_reset();
    m_quiet = 0; m_low = 0; m_rxq = 1; m_missed = 0; m_brk = 0; m_seen = 0;
  endtask

  task automatic model_next();
    int q, l, mi, b, s;
    s = int'(m_rxq == 0 && rx && m_low >= BRK);
    l = rx ? 0 : ((bit_tick && m_low < BRK) ? m_low + 1 : m_low);
    q = !rx ? 0 : ((bit_tick && m_quiet < QMAX) ? m_quiet + 1 : m_quiet);
    if (!rx || !bs_mode) mi = 0;
    else if (m_quiet >= int'(permit_len) && !tx_pending) mi = 1;
    else mi = m_missed;
    if (!rx) b = 0;
    else if ((bs_mode && m_missed && m_quiet > int'(max_idle_len) && tx_pending) ||
             (sw_break && exp_idle())) b = 1;
    else b = m_brk;
    m_quiet = q; m_low = l; m_rxq = int'(rx); m_missed = mi; m_brk = b; m_seen = s;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk("R3 bus_idle", int'(bus_idle), exp_idle());
      chk(bs_mode ? "R5 tx_permit" : "R4 tx_permit", int'(tx_permit), exp_permit());
      chk("R6 break_req", int'(break_req), m_brk);
      chk("R7 break_seen", int'(break_seen), m_seen);
      model_next();
    end else model_reset();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int low_left;
    void'($urandom(32'h5eed_1234));
    model_reset();
    steps(3);
    rst_n = 1;
    #0;
    chk("R1 bus_idle", int'(bus_idle), 0);
    chk("R1 tx_permit", int'(tx_permit), 0);
    chk("R1 break_req", int'(break_req), 0);
    chk("R1 break_seen", int'(break_seen), 0);

    bit_tick = 1;
    steps(9);
    chk("R3 not idle at 9", int'(bus_idle), 0);
    steps(1);
    chk("R3 idle at 10", int'(bus_idle), 1);
    chk("R4 no permit at 10", int'(tx_permit), 0);
    steps(10);
    chk("R4 permit at 20", int'(tx_permit), 1);
    chk("R9 permit without pending", int'(tx_permit), 1);
    rx = 0;
    #1;
    chk("R4 drop on start bit", int'(tx_permit), 0);
    steps(1);
    rx = 1;
    #1;
    chk("R2 count cleared", int'(bus_idle), 0);

    steps(5);
    sw_break = 1; steps(1); sw_break = 0;
    chk("R8 ignored when busy", int'(break_req), 0);
    steps(6);
    sw_break = 1; steps(1); sw_break = 0;
    chk("R8 break when idle", int'(break_req), 1);

    rx = 0; steps(12); rx = 1;
    chk("R6 break_req cleared by low", int'(break_req), 0);
    steps(1);
    chk("R7 break seen", int'(break_seen), 1);
    steps(1);
    chk("R7 single pulse", int'(break_seen), 0);
    rx = 0; steps(4); rx = 1; steps(1);
    chk("R7 short low not a break", int'(break_seen), 0);

    bs_mode = 1; tx_pending = 0;
    steps(25);
    chk("R5 permit withdrawn", int'(tx_permit), 0);
    tx_pending = 1;
    steps(185);
    chk("R6 break requested", int'(break_req), 1);
    chk("R5 still withdrawn", int'(tx_permit), 0);
    rx = 0; steps(11); rx = 1;
    chk("R6 break ends request", int'(break_req), 0);
    steps(20);
    chk("R5 pending at permit point", int'(tx_permit), 1);

    bs_mode = 0; tx_pending = 0;
    steps(1030);
    chk("R2 saturate keeps idle", int'(bus_idle), 1);
    chk("R2 saturate keeps permit", int'(tx_permit), 1);

    low_left = 0;
    for (int ph = 0; ph < 12; ph++) begin
      idle_len = IDLE_W'($urandom_range(0, 15));
      permit_len = CNT_W'($urandom_range(0, 40));
      max_idle_len = CNT_W'($urandom_range(30, 90));
      bs_mode = $urandom_range(0, 1) == 1;
      for (int c = 0; c < 1500; c++) begin
        bit_tick = $urandom_range(0, 3) != 0;
        if ($urandom_range(0, 40) == 0) tx_pending = ~tx_pending;
        sw_break = $urandom_range(0, 30) == 0;
        if (low_left == 0 && $urandom_range(0, 70) == 0) low_left = $urandom_range(1, 14);
        rx = (low_left == 0);
        if (low_left > 0 && bit_tick) low_left--;
        step();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule